// File: doc/BRIEF.md
# Pin Interrupt Front End

This block sits between a bank of general-purpose input pins and a system interrupt controller. Each pin first passes through a two-flop synchroniser and then an optional glitch filter. A detector then applies that pin's selected trigger condition: low level, high level, falling edge, rising edge or either edge. When the condition holds, the block records it in a sticky pending bit. Software reads the pending bits and clears each one by writing 1 to it. A per-pin mask bit, active high for blocking, decides which pending bits may drive the single combined request output.

Software sets the block up through a small word-addressed register port. Writes complete in one cycle. Read data is a combinational function of the address.

Register map (word address, field positions):

- 0: trigger codes, pin n at bits [4n+2:4n]
- 1: filter control, per-pin enables at [7:0], accept length at [15:8]
- 2: mask at [7:0]
- 3: pending at [7:0], write 1 to clear

Top module: `extint_bank`

## Requirements
- R1: After reset, the trigger register reads 0, the filter register reads 0x000001FF (all filters on, length 1), the mask register reads 0xFF, the pending register reads 0, and `irqOut` is low.
- R2: The trigger register holds a 3-bit code for pin n at bits [4n+2:4n]. Bit 4n+3 always reads 0, and a code acts only on its own pin.
- R3: Code 3'b010 sets a pin's pending bit on a high-to-low transition of the filtered input, and on nothing else.
- R4: Code 3'b011 sets pending on a low-to-high transition. Code 3'b100 sets pending on either transition.
- R5: Code 3'b000 sets pending in every cycle the filtered input is low. Code 3'b001 does the same while it is high. A clear therefore does not stick while the level persists.
- R6: Codes 3'b101, 3'b110 and 3'b111 never set pending.
- R7: `irqOut` is high exactly when some pin has pending=1 and mask=0. A masked pin still sets its pending bit.
- R8: Writing address 3 clears every pending bit whose data bit is 1. Bits written with 0 keep their value.
- R9: When a trigger and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: Take a pin change applied before rising edge 1, with an accept length of L. Its pending bit is set after edge 3+L and not after edge 2+L. L counts as 1 when the filter is disabled or the length field is 0.
- R11: With a pin's filter enabled and length L, a change that lasts fewer than L cycles is discarded. A change that lasts L cycles is accepted.
- R12: The filter, mask and pending registers read back their fields at the positions given in the map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register word address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr |
| pinIn | input | 8 | Asynchronous pin inputs |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every trigger code over every pin. It drives each pin through high, low and high again, and compares the whole pending vector after each step, so a field decoded at the wrong bit offset or a reserved code that fires shows up at once. It clears a level-triggered bit while the level is still present; a design where the clear beats the set would read the bit as 0. It counts the exact edge on which pending appears, both with and without the filter, which catches a missing or extra synchroniser stage. Pulses one cycle shorter than the accept length must vanish, and a design that takes a length of 0 literally would either hang or accept nothing.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b011,
    TRIG_BOTH = 3'b100
  } trigCode_e;

  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_FILT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_PEND = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    trigWr;
    logic    filtWr;
    logic    maskWr;
    logic    pendWr;
    logic    rdValid;
    regSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        stb
);

  logic    upperZero;
  regSel_e sel;

  generate
    if (ADDR_W > 2) begin : g_wide
      assign upperZero = ~|busAddr[ADDR_W-1:2];
    end else begin : g_narrow
      assign upperZero = 1'b1;
    end
  endgenerate

  assign sel = regSel_e'(busAddr[1:0]);

  always_comb begin
    stb         = '0;
    stb.rdSel   = sel;
    stb.rdValid = upperZero;
    if (busWrEn && upperZero) begin
      unique case (sel)
        SEL_TRIG: stb.trigWr = 1'b1;
        SEL_FILT: stb.filtWr = 1'b1;
        SEL_MASK: stb.maskWr = 1'b1;
        SEL_PEND: stb.pendWr = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/extint_pin.sv
module extint_pin
  import extint_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinRaw,
  input  logic              filtEn,
  input  logic [FILT_W-1:0] filtLen,
  input  logic [2:0]        trigMode,
  output logic              hit
);

  logic              syncA, syncB;
  logic              filtLvl, prevLvl;
  logic [FILT_W-1:0] stableCnt;
  logic [FILT_W-1:0] needLen;
  logic              reached;
  logic              riseEv, fallEv;

  assign needLen = (filtLen == '0) ? FILT_W'(1) : filtLen;
  assign reached = ({1'b0, stableCnt} + 1'b1) >= {1'b0, needLen};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= 1'b1;
      syncB     <= 1'b1;
      filtLvl   <= 1'b1;
      prevLvl   <= 1'b1;
      stableCnt <= '0;
    end else begin
      syncA   <= pinRaw;
      syncB   <= syncA;
      prevLvl <= filtLvl;
      if (!filtEn) begin
        filtLvl   <= syncB;
        stableCnt <= '0;
      end else if (syncB == filtLvl) begin
        stableCnt <= '0;
      end else if (reached) begin
        filtLvl   <= syncB;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  assign riseEv = filtLvl & ~prevLvl;
  assign fallEv = ~filtLvl & prevLvl;

  always_comb begin
    case (trigMode)
      TRIG_LOW:  hit = ~filtLvl;
      TRIG_HIGH: hit = filtLvl;
      TRIG_FALL: hit = fallEv;
      TRIG_RISE: hit = riseEv;
      TRIG_BOTH: hit = riseEv | fallEv;
      default:   hit = 1'b0;
    endcase
  end

  // R6: reserved codes never raise a trigger
  assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode > 3'b100) |-> !hit);

  // R3: a falling-edge trigger coincides with a drop of the filtered level
  assert_fall_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == 3'b010 && hit) |-> $fell(filtLvl));

  // R11: the filtered level only moves to the value the synchroniser holds
  assert_filter_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    (filtLvl != $past(filtLvl)) |-> (filtLvl == $past(syncB)));

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int FILT_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);

  localparam int FIELD_STRIDE = 4;
  localparam int CODE_W       = 3;
  localparam int LEN_LSB      = NUM_PINS;

  logic [NUM_PINS-1:0][CODE_W-1:0] trigReg;
  logic [NUM_PINS-1:0]             filtEnReg;
  logic [FILT_W-1:0]               filtLenReg;
  logic [NUM_PINS-1:0]             maskReg;
  logic [NUM_PINS-1:0]             pendReg;
  logic [NUM_PINS-1:0]             hitVec;
  logic [NUM_PINS-1:0]             clrVec;
  logic                            unusedPad;

  assign clrVec = stb.pendWr ? wrData[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigReg    <= '0;
      filtEnReg  <= '1;
      filtLenReg <= FILT_W'(1);
      maskReg    <= '1;
      pendReg    <= '0;
    end else begin
      if (stb.trigWr) begin
        for (int i = 0; i < NUM_PINS; i++) begin
          trigReg[i] <= wrData[FIELD_STRIDE*i +: CODE_W];
        end
      end
      if (stb.filtWr) begin
        filtEnReg  <= wrData[NUM_PINS-1:0];
        filtLenReg <= wrData[LEN_LSB +: FILT_W];
      end
      if (stb.maskWr) begin
        maskReg <= wrData[NUM_PINS-1:0];
      end
      pendReg <= (pendReg & ~clrVec) | hitVec;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      extint_pin #(.FILT_W(FILT_W)) u_pin (
        .clk     (clk),
        .rstN    (rstN),
        .pinRaw  (pinIn[p]),
        .filtEn  (filtEnReg[p]),
        .filtLen (filtLenReg),
        .trigMode(trigReg[p]),
        .hit     (hitVec[p])
      );
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (stb.rdValid) begin
      case (stb.rdSel)
        SEL_TRIG: begin
          for (int i = 0; i < NUM_PINS; i++) begin
            rdData[FIELD_STRIDE*i +: CODE_W] = trigReg[i];
          end
        end
        SEL_FILT: begin
          rdData[NUM_PINS-1:0]      = filtEnReg;
          rdData[LEN_LSB +: FILT_W] = filtLenReg;
        end
        SEL_MASK: rdData[NUM_PINS-1:0] = maskReg;
        SEL_PEND: rdData[NUM_PINS-1:0] = pendReg;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unusedPad = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      unusedPad = unusedPad ^ wrData[FIELD_STRIDE*i + CODE_W];
    end
  end

  assign irqOut = |(pendReg & ~maskReg);

  // R8: a cleared bit with no trigger in that cycle reads 0 next cycle
  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendWr |=> ((pendReg & $past(clrVec & ~hitVec)) == '0));

  // R9: a trigger always leaves its pending bit set, whatever else happens
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> ((pendReg & $past(hitVec)) == $past(hitVec)));

  // R8: pending bits not cleared stay set
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|pendReg) |=> ((pendReg & $past(pendReg & ~clrVec)) == $past(pendReg & ~clrVec)));

  // R7: request only raised by an enabled pending bit, and the mask reacts at once
  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '1) |-> !irqOut);

endmodule

// File: rtl/extint_bank.sv
module extint_bank
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int FILT_W   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut
);

  regStrobe_t stb;

  extint_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .stb    (stb)
  );

  extint_datapath #(
    .NUM_PINS(NUM_PINS),
    .FILT_W  (FILT_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(busWrData),
    .pinIn (pinIn),
    .rdData(busRdData),
    .irqOut(irqOut)
  );

endmodule

// File: tb/extint_bank_tb.sv
module extint_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  pins = 8'hFF;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  extint_bank u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .pinIn    (pins),
    .irqOut   (irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a; #0.5; d = busRdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string codeTag(input int c);
    case (c)
      0, 1:    return "R5";
      2:       return "R3";
      3, 4:    return "R4";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cfg, bitP, exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitN(2);

    // R1 reset state
    rd(0, v); check("R1 trig", v, 32'h0);
    rd(1, v); check("R1 filt", v, 32'h0000_01FF);
    rd(2, v); check("R1 mask", v, 32'h0000_00FF);
    rd(3, v); check("R1 pend", v, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R12 / R2 read-back of field positions
    wr(1, 32'hFFFF_05A5); rd(1, v); check("R12 filt", v, 32'h0000_05A5);
    wr(2, 32'hFFFF_FF3C); rd(2, v); check("R12 mask", v, 32'h0000_003C);
    wr(0, 32'hFFFF_FFFF); rd(0, v); check("R2 trig pad", v, 32'h7777_7777);
    wr(0, 32'h7654_3210); rd(0, v); check("R2 trig fields", v, 32'h7654_3210);

    // sweep: every code on every pin, filter off, all unmasked
    wr(1, 32'h0); wr(2, 32'h0);
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 8; c++) begin
        cfg  = (32'h7777_7777 & ~(32'hF << (4 * p))) | (32'(c) << (4 * p));
        bitP = 32'h1 << p;
        wr(0, cfg); wr(3, 32'hFF); waitN(4);
        rd(3, v); exp = (c == 1) ? bitP : 32'h0;
        check({codeTag(c), " R2 idle-high"}, v, exp);
        check("R7 irq follows pending", {31'b0, irqOut}, {31'b0, exp != 0});
        wr(3, 32'hFF);
        pins[p] = 1'b0; waitN(6);
        rd(3, v); exp = (c == 0 || c == 1 || c == 2 || c == 4) ? bitP : 32'h0;
        check({codeTag(c), " R2 after fall"}, v, exp);
        wr(3, 32'hFF);
        pins[p] = 1'b1; waitN(6);
        rd(3, v); exp = (c == 0 || c == 1 || c == 3 || c == 4) ? bitP : 32'h0;
        check({codeTag(c), " R2 after rise"}, v, exp);
        wr(3, 32'hFF);
      end
    end

    // R7 masking
    wr(0, 32'h7777_7772); wr(2, 32'h01); wr(3, 32'hFF);
    pins[0] = 1'b0; waitN(6); pins[0] = 1'b1; waitN(6);
    rd(3, v); check("R7 masked pin pends", v, 32'h01);
    check("R7 masked irq low", {31'b0, irqOut}, 32'h0);
    wr(2, 32'h00); check("R7 unmask irq high", {31'b0, irqOut}, 32'h1);
    wr(2, 32'h01); check("R7 remask irq low", {31'b0, irqOut}, 32'h0);

    // R8 write-one-to-clear
    wr(0, 32'h7777_7722); wr(2, 32'hFF); wr(3, 32'hFF);
    pins[1:0] = 2'b00; waitN(6); pins[1:0] = 2'b11; waitN(6);
    rd(3, v); check("R8 both set", v, 32'h03);
    wr(3, 32'h00); rd(3, v); check("R8 zero write keeps", v, 32'h03);
    wr(3, 32'h02); rd(3, v); check("R8 clear one bit", v, 32'h01);
    wr(3, 32'h01); rd(3, v); check("R8 clear other", v, 32'h00);

    // R9 set beats clear while low level persists
    wr(0, 32'h7777_7077);
    pins[2] = 1'b0; waitN(6);
    wr(3, 32'h04); rd(3, v); check("R9 set wins", v, 32'h04);
    pins[2] = 1'b1; waitN(6);
    wr(3, 32'h04); rd(3, v); check("R9 clear after level gone", v, 32'h00);

    // R10 latency, filter off then length 4
    wr(0, 32'h7777_2777); wr(1, 32'h0); wr(3, 32'hFF);
    pins[3] = 1'b0; waitN(3);
    rd(3, v); check("R10 nofilt edge3", v, 32'h00);
    waitN(1); rd(3, v); check("R10 nofilt edge4", v, 32'h08);
    pins[3] = 1'b1; waitN(8);
    wr(1, 32'h0000_0408); wr(3, 32'hFF);
    pins[3] = 1'b0; waitN(6);
    rd(3, v); check("R10 len4 edge6", v, 32'h00);
    waitN(1); rd(3, v); check("R10 len4 edge7", v, 32'h08);
    pins[3] = 1'b1; waitN(10); wr(3, 32'hFF);

    // R11 glitch filter on pin 4, length 4
    wr(0, 32'h7772_7777); wr(1, 32'h0000_0410); wr(3, 32'hFF);
    pins[4] = 1'b0; repeat (3) @(negedge clk); pins[4] = 1'b1; waitN(12);
    rd(3, v); check("R11 short pulse dropped", v, 32'h00);
    pins[4] = 1'b0; repeat (4) @(negedge clk); pins[4] = 1'b1; waitN(12);
    rd(3, v); check("R11 full pulse kept", v, 32'h10);
    wr(3, 32'hFF);
    wr(1, 32'h0000_0010);
    pins[4] = 1'b0; @(negedge clk); pins[4] = 1'b1; waitN(10);
    rd(3, v); check("R11 length0 as 1", v, 32'h10);
    wr(3, 32'hFF);
    wr(1, 32'h0000_0210);
    pins[4] = 1'b0; @(negedge clk); pins[4] = 1'b1; waitN(10);
    rd(3, v); check("R11 len2 one-cycle dropped", v, 32'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule